// File: doc/BRIEF.md
# Subscriber Line State Controller

This block is the supervisory sequencer for one analogue subscriber line interface. It decides which of four line conditions the interface is in: powered off, high-impedance standby, active feed, or ringing. It drives the four mode-select pins that carry that decision. It also watches the interface's single active-low detector output. In standby and active feed, the detector reports off-hook. While the line rings, it reports ring trip. The block reads the detector according to its current state.

The block makes the ringing signal itself. During a ring burst it flips the polarity pin every half period of the ring frequency. Bursts alternate with silent pauses, and during a pause the line sits in active feed with normal polarity. A trip, seen in a burst or in a pause, first freezes the polarity pin low. One cycle later the line moves to active feed. A host sends four commands: power down, standby, start ringing and select polarity. It also supplies the timer limits as plain input words. A two-bit status word and an off-hook flag report back to the host.

Top module: `line_sup_ctrl`

## Requirements
- R1: While `rst` is high and right after it is released, the state code is 0 (off), all four pins are 0 and `stat_offhook` is 0.
- R2: The pins {`pwr_en_o`,`mode_a_o`,`mode_b_o`,`pol_o`} follow the state code: off (0) = 0000, standby (1) = 1000, active (2) = 101r where r is the held polarity, ringing (3) = 110f in a burst (f is the ring phase) and 1010 in a pause, trip (4) = 1100.
- R3: A command takes effect at the first clock edge that samples `cmd_valid` high. `cmd_op` 0 means power down and 1 means standby; both work from any state. `cmd_op` 2 starts ringing, but only from standby, and is ignored in every other state. `cmd_op` 3 loads `cmd_rev` as the polarity. A state-changing command takes priority over a detector event in the same cycle.
- R4: `hook_det_n` passes through two synchroniser flops and then a run-length filter. The filtered value and `stat_offhook` change at the 6th edge after an input change, with default parameters. A pulse of 2 cycles or less leaves them unchanged.
- R5: In standby, a filtered off-hook moves the state to active one edge after `stat_offhook` rises.
- R6: In active, a filtered on-hook that lasts `cfg_qual` cycles returns the line to standby. Any earlier return to off-hook restarts the count.
- R7: In a burst, `pol_o` starts at 0 and inverts every `cfg_half` cycles.
- R8: Ringing repeats `cfg_burst` burst cycles followed by `cfg_pause` pause cycles, counted from the edge that entered ringing. Each new burst starts with phase 0.
- R9: A filtered off-hook during ringing, in a burst or a pause, gives one cycle of the trip state (pins 1100), then active.
- R10: In the off state the detector is ignored: the state stays off and `stat_offhook` stays 0.
- R11: In active, `pol_o` equals the polarity last loaded by command 3. This includes entry from a ring trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hook_det_n | input | 1 | Asynchronous active-low detector from the line interface |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_op | input | 2 | Command code: 0 power down, 1 standby, 2 ring, 3 polarity |
| cmd_rev | input | 1 | Polarity value for command 3 (1 = reversed) |
| cfg_half | input | HALF_W | Ring half period in clock cycles |
| cfg_burst | input | SEG_W | Ring burst length in clock cycles |
| cfg_pause | input | SEG_W | Ring pause length in clock cycles |
| cfg_qual | input | QUAL_W | On-hook qualification time in clock cycles |
| pwr_en_o | output | 1 | Interface power enable (0 = powered down) |
| mode_a_o | output | 1 | Mode select bit A (ring select) |
| mode_b_o | output | 1 | Mode select bit B (active select) |
| pol_o | output | 1 | Polarity / ring toggle bit |
| stat_state | output | 3 | Current state code |
| stat_offhook | output | 1 | Filtered off-hook, forced 0 while off |

## Verification
Commands show on the pins one edge after the strobe. A detector change reaches `stat_offhook` at edge 6. It reaches the state one edge later (standby to active or ring to trip), and the trip state is followed by active one edge after that. An on-hook return lands `cfg_qual` edges after the filtered flag drops. The ring pattern is computed per cycle from the number of edges since ringing began. The bench drives every input just after a falling edge. It counts whole cycles to the edge where each result is due and samples on the next falling edge. Each latency is checked both one cycle early and on time.

// File: rtl/line_sup_pkg.sv
package line_sup_pkg;

    typedef enum logic [2:0] {
        LS_OFF  = 3'd0,
        LS_STBY = 3'd1,
        LS_ACT  = 3'd2,
        LS_RING = 3'd3,
        LS_TRIP = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        OP_PWRDN = 2'd0,
        OP_STBY  = 2'd1,
        OP_RING  = 2'd2,
        OP_POL   = 2'd3
    } host_op_e;

    typedef struct packed {
        logic pwr;
        logic sel_a;
        logic sel_b;
        logic pol;
    } ctl_pins_t;

    // Pin pattern for each state; ring pauses fall back to normal active feed.
    function automatic ctl_pins_t pins_for(line_state_e st, logic burst,
                                           logic phase, logic rev);
        ctl_pins_t p;
        p = '0;
        case (st)
            LS_STBY: p.pwr = 1'b1;
            LS_ACT: begin
                p.pwr   = 1'b1;
                p.sel_b = 1'b1;
                p.pol   = rev;
            end
            LS_RING: begin
                p.pwr = 1'b1;
                if (burst) begin
                    p.sel_a = 1'b1;
                    p.pol   = phase;
                end else begin
                    p.sel_b = 1'b1;
                end
            end
            LS_TRIP: begin
                p.pwr   = 1'b1;
                p.sel_a = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/line_det_filter.sv
module line_det_filter #(
    parameter int SYNC_N  = 2,
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic det_n_i,
    output logic hook_n_o
);
    localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
    localparam logic [CW-1:0] RUN_LAST = CW'(DEB_CYC - 1);

    logic [SYNC_N-1:0] sync_q;
    logic [CW-1:0]     run_q;
    logic              stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            run_q    <= '0;
            stable_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], det_n_i};
            if (sync_q[SYNC_N-1] != stable_q) begin
                if (run_q == RUN_LAST) begin
                    stable_q <= sync_q[SYNC_N-1];
                    run_q    <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign hook_n_o = stable_q;
endmodule

// File: rtl/line_ring_cadence.sv
module line_ring_cadence #(
    parameter int HW = 16,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [HW-1:0] half_cyc,
    input  logic [CW-1:0] burst_cyc,
    input  logic [CW-1:0] pause_cyc,
    output logic          in_burst_o,
    output logic          phase_o
);
    logic [HW-1:0] half_q;
    logic [CW-1:0] seg_q;
    logic [HW-1:0] half_last;
    logic [CW-1:0] burst_last;
    logic [CW-1:0] pause_last;
    logic [CW-1:0] seg_last;

    assign half_last  = (half_cyc  == '0) ? '0 : half_cyc  - 1'b1;
    assign burst_last = (burst_cyc == '0) ? '0 : burst_cyc - 1'b1;
    assign pause_last = (pause_cyc == '0) ? '0 : pause_cyc - 1'b1;
    assign seg_last   = in_burst_o ? burst_last : pause_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            in_burst_o <= 1'b1;
            seg_q      <= '0;
            half_q     <= '0;
            phase_o    <= 1'b0;
        end else if (seg_q == seg_last) begin
            in_burst_o <= ~in_burst_o;
            seg_q      <= '0;
            half_q     <= '0;
            phase_o    <= 1'b0;
        end else begin
            seg_q <= seg_q + 1'b1;
            if (in_burst_o) begin
                if (half_q == half_last) begin
                    half_q  <= '0;
                    phase_o <= ~phase_o;
                end else begin
                    half_q <= half_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/line_qual_timer.sv
module line_qual_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         hold,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    assign last   = (limit == '0) ? '0 : limit - 1'b1;
    assign expire = arm && hold && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !arm || !hold) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/line_sup_ctrl.sv
module line_sup_ctrl
    import line_sup_pkg::*;
#(
    parameter int SYNC_N  = 2,
    parameter int DEB_CYC = 4,
    parameter int HALF_W  = 16,
    parameter int SEG_W   = 24,
    parameter int QUAL_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hook_det_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_rev,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [SEG_W-1:0]  cfg_burst,
    input  logic [SEG_W-1:0]  cfg_pause,
    input  logic [QUAL_W-1:0] cfg_qual,
    output logic              pwr_en_o,
    output logic              mode_a_o,
    output logic              mode_b_o,
    output logic              pol_o,
    output logic [2:0]        stat_state,
    output logic              stat_offhook
);
    line_state_e state_q, state_d;
    logic        rev_q, rev_d;
    logic        hook_n;
    logic        in_burst, phase;
    logic        qual_exp;
    logic        cmd_move;
    host_op_e    op;
    ctl_pins_t   pins;

    line_det_filter #(.SYNC_N(SYNC_N), .DEB_CYC(DEB_CYC)) u_filt (
        .clk(clk), .rst(rst), .det_n_i(hook_det_n), .hook_n_o(hook_n)
    );

    line_ring_cadence #(.HW(HALF_W), .CW(SEG_W)) u_ring (
        .clk(clk), .rst(rst), .en(state_q == LS_RING),
        .half_cyc(cfg_half), .burst_cyc(cfg_burst), .pause_cyc(cfg_pause),
        .in_burst_o(in_burst), .phase_o(phase)
    );

    line_qual_timer #(.W(QUAL_W)) u_qual (
        .clk(clk), .rst(rst), .arm(state_q == LS_ACT), .hold(hook_n),
        .limit(cfg_qual), .expire(qual_exp)
    );

    assign op = host_op_e'(cmd_op);

    always_comb begin
        cmd_move = 1'b0;
        state_d  = state_q;
        rev_d    = rev_q;
        if (cmd_valid) begin
            case (op)
                OP_PWRDN: begin
                    state_d  = LS_OFF;
                    cmd_move = 1'b1;
                end
                OP_STBY: begin
                    state_d  = LS_STBY;
                    cmd_move = 1'b1;
                end
                OP_RING: if (state_q == LS_STBY) begin
                    state_d  = LS_RING;
                    cmd_move = 1'b1;
                end
                default: rev_d = cmd_rev;
            endcase
        end
        if (!cmd_move) begin
            case (state_q)
                LS_STBY: if (!hook_n) state_d = LS_ACT;
                LS_ACT:  if (qual_exp) state_d = LS_STBY;
                LS_RING: if (!hook_n) state_d = LS_TRIP;
                LS_TRIP: state_d = LS_ACT;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_OFF;
            rev_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rev_q   <= rev_d;
        end
    end

    assign pins         = pins_for(state_q, in_burst, phase, rev_q);
    assign pwr_en_o     = pins.pwr;
    assign mode_a_o     = pins.sel_a;
    assign mode_b_o     = pins.sel_b;
    assign pol_o        = pins.pol;
    assign stat_state   = state_q;
    assign stat_offhook = (state_q != LS_OFF) && !hook_n;
endmodule

// File: rtl/line_sup_chk.sv
module line_sup_chk
    import line_sup_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       pwr_en_o,
    input logic       mode_a_o,
    input logic       mode_b_o,
    input logic       pol_o,
    input logic [2:0] stat_state,
    input logic       stat_offhook
);
    // R1
    reset_off_chk: assert property (@(posedge clk)
        rst |=> (stat_state == LS_OFF && !pwr_en_o && !stat_offhook));

    // R3
    pwrdn_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PWRDN) |=> (stat_state == LS_OFF));

    // R5
    stby_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_state == LS_STBY && stat_offhook && !cmd_valid) |=> (stat_state == LS_ACT));

    // R8
    pause_feed_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_state == LS_RING && !mode_a_o) |-> (mode_b_o && !pol_o && pwr_en_o));

    // R9
    trip_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_state == LS_TRIP && !cmd_valid) |=> (stat_state == LS_ACT));

    // R9
    trip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_state == LS_TRIP) |-> (mode_a_o && !mode_b_o && !pol_o));

    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_state == LS_OFF && !(cmd_valid && cmd_op == OP_STBY)) |=> (stat_state == LS_OFF));
endmodule

bind line_sup_ctrl line_sup_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pwr_en_o(pwr_en_o), .mode_a_o(mode_a_o), .mode_b_o(mode_b_o), .pol_o(pol_o),
    .stat_state(stat_state), .stat_offhook(stat_offhook)
);

// File: tb/sim_line_sup_ctrl.sv
module sim_line_sup_ctrl;
    localparam int LAT = 6;   // sync (2) + filter run (4)
    localparam int QV  = 20;

    logic        clk, rst, hook_det_n, cmd_valid, cmd_rev;
    logic [1:0]  cmd_op;
    logic [15:0] cfg_half;
    logic [23:0] cfg_burst, cfg_pause, cfg_qual;
    logic        pwr_en_o, mode_a_o, mode_b_o, pol_o, stat_offhook;
    logic [2:0]  stat_state;
    logic [3:0]  pins;
    int          n_chk, n_err;
    int unsigned hv, bv, pv;

    line_sup_ctrl u0 (
        .clk(clk), .rst(rst), .hook_det_n(hook_det_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_rev(cmd_rev), .cfg_half(cfg_half), .cfg_burst(cfg_burst),
        .cfg_pause(cfg_pause), .cfg_qual(cfg_qual), .pwr_en_o(pwr_en_o),
        .mode_a_o(mode_a_o), .mode_b_o(mode_b_o), .pol_o(pol_o),
        .stat_state(stat_state), .stat_offhook(stat_offhook)
    );

    assign pins = {pwr_en_o, mode_a_o, mode_b_o, pol_o};

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic rv);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_rev   = rv;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [3:0] ring_exp(int k, int h, int b, int p);
        int m;
        m = k % (b + p);
        if (m < b) return {3'b110, 1'((m / h) % 2)};
        return 4'b1010;
    endfunction

    task automatic ring_run(input int len, input int h, input int b, input int p, input string tag);
        for (int k = 0; k < len; k++) begin
            check({tag, " state"}, 32'(stat_state), 32'd3);
            check(tag, 32'(pins), 32'(ring_exp(k, h, b, p)));
            tick(1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        n_chk = 0; n_err = 0;
        void'($urandom(32'd4711));
        rst = 1'b1; hook_det_n = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_rev = 1'b0;
        cfg_half = 16'd5; cfg_burst = 24'd40; cfg_pause = 24'd30; cfg_qual = 24'(QV);
        tick(3);
        rst = 1'b0;
        check("R1 state", 32'(stat_state), 32'd0);
        check("R1 pins", 32'(pins), 32'h0);
        check("R1 offhook", 32'(stat_offhook), 32'd0);

        // R10: detector ignored while off; ring command ignored (R3)
        hook_det_n = 1'b0;
        tick(LAT + 5);
        check("R10 state", 32'(stat_state), 32'd0);
        check("R10 offhook", 32'(stat_offhook), 32'd0);
        send(2'd2, 1'b0);
        check("R3 ring ignored when off", 32'(stat_state), 32'd0);
        hook_det_n = 1'b1;
        tick(LAT + 2);

        send(2'd1, 1'b0);
        check("R3 standby", 32'(stat_state), 32'd1);
        check("R2 standby pins", 32'(pins), 32'h8);

        // R4: short glitch filtered
        hook_det_n = 1'b0;
        tick(2);
        hook_det_n = 1'b1;
        tick(LAT + 4);
        check("R4 glitch state", 32'(stat_state), 32'd1);
        check("R4 glitch offhook", 32'(stat_offhook), 32'd0);

        // R4/R5: off-hook latency
        hook_det_n = 1'b0;
        tick(LAT - 1);
        check("R4 early offhook", 32'(stat_offhook), 32'd0);
        tick(1);
        check("R4 offhook", 32'(stat_offhook), 32'd1);
        check("R5 not yet", 32'(stat_state), 32'd1);
        tick(1);
        check("R5 active", 32'(stat_state), 32'd2);
        check("R2 active pins", 32'(pins), 32'hA);

        // R11 polarity, R3 ring ignored in active
        send(2'd3, 1'b1);
        check("R11 reversed", 32'(pins), 32'hB);
        send(2'd2, 1'b0);
        check("R3 ring ignored in active", 32'(stat_state), 32'd2);
        send(2'd3, 1'b0);
        check("R11 normal", 32'(pins), 32'hA);

        // R6: interrupted on-hook keeps active
        hook_det_n = 1'b1;
        tick(5);
        hook_det_n = 1'b0;
        tick(LAT + QV + 5);
        check("R6 interrupted", 32'(stat_state), 32'd2);
        hook_det_n = 1'b1;
        tick(LAT + QV - 1);
        check("R6 early", 32'(stat_state), 32'd2);
        tick(1);
        check("R6 standby", 32'(stat_state), 32'd1);

        // R7/R8 ring pattern, R9 trip in pause
        send(2'd2, 1'b0);
        ring_run(40 + 30 + 40 + 3, 5, 40, 30, "R7 R8 ring");
        hook_det_n = 1'b0;
        tick(LAT);
        check("R9 pause trip not yet", 32'(stat_state), 32'd3);
        tick(1);
        check("R9 pause trip state", 32'(stat_state), 32'd4);
        check("R9 trip pins", 32'(pins), 32'hC);
        tick(1);
        check("R9 active after trip", 32'(stat_state), 32'd2);
        check("R11 after trip", 32'(pins), 32'hA);

        hook_det_n = 1'b1;
        tick(LAT + 1);
        send(2'd1, 1'b0);
        check("R3 standby from active", 32'(stat_state), 32'd1);

        // R9 trip in burst; R11 polarity loaded while ringing
        send(2'd2, 1'b0);
        send(2'd3, 1'b1);
        tick(1);
        hook_det_n = 1'b0;
        tick(LAT + 1);
        check("R9 burst trip state", 32'(stat_state), 32'd4);
        check("R9 burst trip pins", 32'(pins), 32'hC);
        tick(1);
        check("R9 burst active", 32'(stat_state), 32'd2);
        check("R11 active reversed", 32'(pins), 32'hB);

        send(2'd0, 1'b0);
        check("R3 power down", 32'(stat_state), 32'd0);
        check("R2 off pins", 32'(pins), 32'h0);
        check("R10 offhook masked", 32'(stat_offhook), 32'd0);

        // random ring cadences
        send(2'd3, 1'b0);
        hook_det_n = 1'b1;
        tick(LAT + 2);
        send(2'd1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            hv = 2 + ($urandom % 8);
            bv = hv * (2 + ($urandom % 6));
            pv = 8 + ($urandom % 30);
            cfg_half  = 16'(hv);
            cfg_burst = 24'(bv);
            cfg_pause = 24'(pv);
            send(2'd2, 1'b0);
            ring_run(int'(bv + pv + bv + 4), int'(hv), int'(bv), int'(pv), "R8 random ring");
            send(2'd1, 1'b0);
            check("R3 ring to standby", 32'(stat_state), 32'd1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule